// File: doc/BRIEF.md
# Video DMA Cycle Slot Scheduler

This block decides, cycle by cycle across a scan line, which memory access the video controller makes. The candidates are a missile data fetch, a player data fetch, a display list instruction fetch, a display list address operand fetch, a character code fetch and a memory refresh. When none of them is granted, the CPU keeps the bus. An external horizontal counter supplies the cycle position within the line. At line start the block takes per-line flags: whether an instruction is due, whether address operand bytes follow, and whether the line is a badline.

Player and missile accesses sit in fixed cycles. The display list instruction fetch takes over the missile cycle when missile DMA is off. Operand bytes start at the player 3 cycle. Character codes start where the chosen playfield width begins. Refresh requests arrive in a bunch and are served in free cycles. Any that cannot be served wait in a small backlog. If a badline has playfield DMA off while display list DMA stays on, the block flags the line so the character buffer is reused instead of refilled.

Top module: `vdma_slot_sched`

## Requirements
- R1: `slot_gnt` is one-hot or zero. Bit 0 is missile, bit 1 player, bit 2 display list instruction, bit 3 address operand, bit 4 character code and bit 5 refresh.
- R2: With `msl_en` high, bit 0 is granted at cycle MSL_CYC (default 0). With `plr_en` high, bit 1 is granted at cycles PLR_CYC0 to PLR_CYC0+3 (default 2..5). These grants always win their cycle.
- R3: When `dl_en` and `instr_due` are high at cycle 0, one instruction fetch is pending. It is eligible from cycle MSL_CYC if `msl_en` is low, and from DLI_CYC (default 1) otherwise. It is granted in the first eligible cycle not taken by a higher access.
- R4: When `dl_en` and `opnd_pend` are high at cycle 0, OPND_BYTES (default 2) operand fetches are pending. They are eligible from the player 3 cycle once no instruction fetch is pending, and they are deferred past a taken player 3 cycle.
- R5: On a badline with `pf_width` nonzero, character fetches are pending. Width code 1 gives 32 fetches from cycle 28, code 2 gives 40 from cycle 24, and code 3 gives 48 from cycle 20. One fetch is made per free eligible cycle.
- R6: On a badline with `pf_width` = 0 and `dl_en` high, no character fetch occurs and `chr_reuse` is high for the whole line. Otherwise `chr_reuse` is low.
- R7: Below player and missile, the priority order is instruction, then operand, then character, then refresh.
- R8: Each cycle with `refresh_req` high adds one refresh request. Requests are granted in cycles left free by all other accesses. The backlog is capped at 8, and requests beyond the cap are dropped.
- R9: `rfsh_row` advances by one for each granted refresh cycle and wraps modulo 128.
- R10: `cpu_halt` is high exactly in cycles where some slot is granted.
- R11: After reset `rfsh_row` is 0, no refresh backlog remains and no line fetch is pending.
- R12: At each cycle 0, any instruction, operand or character fetch left over from the previous line is dropped, and the new line's flags set the pending work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcnt | input | 8 | Horizontal cycle position, 0 starts a line |
| pf_width | input | 2 | Playfield width code, 0 means playfield DMA off |
| dl_en | input | 1 | Display list DMA enable |
| msl_en | input | 1 | Missile DMA enable |
| plr_en | input | 1 | Player DMA enable |
| badline | input | 1 | Line needs fresh character codes (sampled at cycle 0) |
| instr_due | input | 1 | Display list instruction fetch needed (sampled at cycle 0) |
| opnd_pend | input | 1 | Address operand bytes follow (sampled at cycle 0) |
| refresh_req | input | 1 | One refresh request this cycle |
| slot_gnt | output | 6 | One-hot granted access |
| cpu_halt | output | 1 | CPU loses the bus this cycle |
| rfsh_row | output | 7 | Refresh row address |
| chr_reuse | output | 1 | Line reuses buffered character codes |

## Verification
The bench builds the block with its default parameters: missile at cycle 0, instruction at cycle 1, players at cycles 2 to 5, two operand bytes, a 40-cycle normal playfield starting at cycle 24 with a step of 8, and an 8-deep refresh backlog. Lines are 114 cycles long. With these values, the cycle where the missile slot is lent to the instruction fetch and the cycle where operands collide with player 3 both fall at the start of the line. A refresh burst placed inside a 48-cycle wide playfield fills the backlog past its cap. Sixteen refresh-heavy lines push the row counter through its wrap, and a deliberately shortened line exercises the dropping of leftover work.

// File: rtl/vdma_sched_pkg.sv
package vdma_sched_pkg;
  localparam int NSLOT = 6;
  localparam int NTRK  = 3;

  typedef enum logic [2:0] {
    SL_MSL   = 3'd0,
    SL_PLR   = 3'd1,
    SL_INSTR = 3'd2,
    SL_OPND  = 3'd3,
    SL_CHR   = 3'd4,
    SL_RFSH  = 3'd5
  } slot_e;

  typedef logic [NSLOT-1:0] slot_vec_t;
endpackage

// File: rtl/vdma_req_track.sv
module vdma_req_track #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [CNT_W-1:0] arm_cnt,
  input  logic             grant,
  output logic             pending
);
  logic [CNT_W-1:0] cnt_q, cnt_cur, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_cur = line_start ? arm_cnt : cnt_q;
    pending = (cnt_cur != '0);
    cnt_d   = cnt_cur - CNT_W'(grant);
    cnt_en  = line_start | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vdma_rfsh_ctl.sv
module vdma_rfsh_ctl #(
  parameter int ROW_W  = 7,
  parameter int BL_MAX = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             grant,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int BL_W = $clog2(BL_MAX + 1);

  logic [BL_W-1:0]  bl_q, bl_d;
  logic [BL_W:0]    bl_sum;
  logic [ROW_W-1:0] row_q, row_d;
  logic             bl_en;

  always_comb begin
    pending = req | (bl_q != '0);
    bl_sum  = {1'b0, bl_q} + (BL_W+1)'(req) - (BL_W+1)'(grant);
    if (bl_sum > (BL_W+1)'(BL_MAX)) bl_d = BL_W'(BL_MAX);
    else                             bl_d = bl_sum[BL_W-1:0];
    bl_en   = req | grant;
    row_d   = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bl_q <= '0;
    else if (bl_en) bl_q <= bl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row_q <= '0;
    else if (grant) row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/vdma_slot_arb.sv
module vdma_slot_arb #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // lowest index wins: isolate the least significant set bit
  always_comb gnt = req & (~req + N'(1));
endmodule

// File: rtl/vdma_slot_sched.sv
module vdma_slot_sched
  import vdma_sched_pkg::*;
#(
  parameter int HCNT_W         = 8,
  parameter int MSL_CYC        = 0,
  parameter int DLI_CYC        = 1,
  parameter int PLR_CYC0       = 2,
  parameter int NPLR           = 4,
  parameter int OPND_BYTES     = 2,
  parameter int CHR_NORM_START = 24,
  parameter int CHR_NORM_LEN   = 40,
  parameter int CHR_STEP       = 8,
  parameter int ROW_W          = 7,
  parameter int RF_BL_MAX      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [1:0]        pf_width,
  input  logic              dl_en,
  input  logic              msl_en,
  input  logic              plr_en,
  input  logic              badline,
  input  logic              instr_due,
  input  logic              opnd_pend,
  input  logic              refresh_req,
  output logic [5:0]        slot_gnt,
  output logic              cpu_halt,
  output logic [ROW_W-1:0]  rfsh_row,
  output logic              chr_reuse
);
  localparam int CNT_W    = $clog2(CHR_NORM_LEN + CHR_STEP + 1);
  localparam int PLR_LAST = PLR_CYC0 + NPLR - 1;
  localparam int HALF     = CHR_STEP / 2;
  localparam int TRK_BASE = int'(SL_INSTR);

  logic             line_start;
  logic [HCNT_W-1:0] chr_start;
  logic [CNT_W-1:0]  chr_len;
  logic [CNT_W-1:0]  arm_cnt [NTRK];
  logic [NTRK-1:0]   elig, pend;
  slot_vec_t         req, gnt;
  logic              rf_pend;
  logic              reuse_now, reuse_q;

  always_comb begin
    line_start = (hcnt == '0);
    case (pf_width)
      2'd1:    begin chr_start = HCNT_W'(CHR_NORM_START + HALF);
                     chr_len   = CNT_W'(CHR_NORM_LEN - CHR_STEP); end
      2'd3:    begin chr_start = HCNT_W'(CHR_NORM_START - HALF);
                     chr_len   = CNT_W'(CHR_NORM_LEN + CHR_STEP); end
      default: begin chr_start = HCNT_W'(CHR_NORM_START);
                     chr_len   = CNT_W'(CHR_NORM_LEN); end
    endcase
    arm_cnt[0] = (dl_en && instr_due) ? CNT_W'(1) : '0;
    arm_cnt[1] = (dl_en && opnd_pend) ? CNT_W'(OPND_BYTES) : '0;
    arm_cnt[2] = (badline && pf_width != 2'd0) ? chr_len : '0;
    // instruction borrows the missile cycle when missile DMA is off
    elig[0] = hcnt >= (msl_en ? HCNT_W'(DLI_CYC) : HCNT_W'(MSL_CYC));
    elig[1] = (hcnt >= HCNT_W'(PLR_LAST)) && !pend[0];
    elig[2] = hcnt >= chr_start;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NTRK; gi++) begin : g_trk
      vdma_req_track #(.CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .arm_cnt   (arm_cnt[gi]),
        .grant     (gnt[TRK_BASE + gi]),
        .pending   (pend[gi])
      );
    end
  endgenerate

  vdma_rfsh_ctl #(.ROW_W(ROW_W), .BL_MAX(RF_BL_MAX)) u_rfsh (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (refresh_req),
    .grant  (gnt[SL_RFSH]),
    .pending(rf_pend),
    .row    (rfsh_row)
  );

  always_comb begin
    req           = '0;
    req[SL_MSL]   = msl_en && (hcnt == HCNT_W'(MSL_CYC));
    req[SL_PLR]   = plr_en && (hcnt >= HCNT_W'(PLR_CYC0)) && (hcnt <= HCNT_W'(PLR_LAST));
    req[SL_INSTR] = pend[0] && elig[0];
    req[SL_OPND]  = pend[1] && elig[1];
    req[SL_CHR]   = pend[2] && elig[2];
    req[SL_RFSH]  = rf_pend;
  end

  vdma_slot_arb #(.N(NSLOT)) u_arb (
    .req(req),
    .gnt(gnt)
  );

  always_comb reuse_now = badline && dl_en && (pf_width == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          reuse_q <= 1'b0;
    else if (line_start) reuse_q <= reuse_now;
  end

  assign slot_gnt  = gnt;
  assign cpu_halt  = |gnt;
  assign chr_reuse = line_start ? reuse_now : reuse_q;
endmodule

// File: rtl/vdma_slot_sched_chk.sv
module vdma_slot_sched_chk #(
  parameter int HCNT_W   = 8,
  parameter int PLR_CYC0 = 2,
  parameter int NPLR     = 4,
  parameter int ROW_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HCNT_W-1:0] hcnt,
  input logic              msl_en,
  input logic              plr_en,
  input logic [5:0]        slot_gnt,
  input logic [ROW_W-1:0]  rfsh_row,
  input logic              chr_reuse
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_gnt));

  a_r2_msl_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    slot_gnt[0] |-> msl_en);

  a_r2_player_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (plr_en && hcnt >= HCNT_W'(PLR_CYC0) && hcnt <= HCNT_W'(PLR_CYC0 + NPLR - 1))
      |-> slot_gnt[1]);

  a_r6_no_chr_on_reuse: assert property (@(posedge clk) disable iff (!rst_n)
    chr_reuse |-> !slot_gnt[4]);

  a_r9_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    slot_gnt[5] |=> rfsh_row == ROW_W'($past(rfsh_row) + 1'b1));

  a_r9_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_gnt[5] |=> $stable(rfsh_row));
endmodule

bind vdma_slot_sched vdma_slot_sched_chk #(
  .HCNT_W  (HCNT_W),
  .PLR_CYC0(PLR_CYC0),
  .NPLR    (NPLR),
  .ROW_W   (ROW_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hcnt     (hcnt),
  .msl_en   (msl_en),
  .plr_en   (plr_en),
  .slot_gnt (slot_gnt),
  .rfsh_row (rfsh_row),
  .chr_reuse(chr_reuse)
);

// File: tb/vdma_slot_sched_tb_top.sv
module vdma_slot_sched_tb_top;
  localparam time CLK_PERIOD = 10;
  localparam int  LINE       = 114;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] hcnt;
  logic [1:0] pf_width;
  logic       dl_en, msl_en, plr_en, badline, instr_due, opnd_pend, refresh_req;
  logic [5:0] slot_gnt;
  logic       cpu_halt;
  logic [6:0] rfsh_row;
  logic       chr_reuse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int m_instr, m_opnd, m_chr, m_bl, m_row;
  bit m_reuse;

  vdma_slot_sched dut_i (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .pf_width(pf_width), .dl_en(dl_en),
    .msl_en(msl_en), .plr_en(plr_en), .badline(badline), .instr_due(instr_due),
    .opnd_pend(opnd_pend), .refresh_req(refresh_req), .slot_gnt(slot_gnt),
    .cpu_halt(cpu_halt), .rfsh_row(rfsh_row), .chr_reuse(chr_reuse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at hcnt=%0d act=%0d exp=%0d", tag, what, hcnt, act, exp);
    end
  endtask

  function automatic int chr_count(input int w);
    return (w == 1) ? 32 : (w == 3) ? 48 : 40;
  endfunction

  function automatic int chr_first(input int w);
    return (w == 1) ? 28 : (w == 3) ? 20 : 24;
  endfunction

  task automatic eval_and_step(input string tag);
    bit ls;
    int ei, eo, ec, who, expv;
    bit er;
    ls = (hcnt == 0);
    ei = ls ? ((dl_en && instr_due) ? 1 : 0) : m_instr;
    eo = ls ? ((dl_en && opnd_pend) ? 2 : 0) : m_opnd;
    ec = ls ? ((badline && pf_width != 0) ? chr_count(pf_width) : 0) : m_chr;
    er = ls ? (badline && dl_en && pf_width == 0) : m_reuse;
    if (msl_en && hcnt == 0)                               who = 0;
    else if (plr_en && hcnt >= 2 && hcnt <= 5)             who = 1;
    else if (ei > 0 && int'(hcnt) >= (msl_en ? 1 : 0))     who = 2;
    else if (eo > 0 && ei == 0 && hcnt >= 5)               who = 3;
    else if (ec > 0 && int'(hcnt) >= chr_first(pf_width))  who = 4;
    else if (m_bl > 0 || refresh_req)                      who = 5;
    else                                                   who = -1;
    expv = (who < 0) ? 0 : (1 << who);
    chk(tag,   "slot grant",     int'(slot_gnt), expv);
    chk("R1",  "grant popcount", $countones(slot_gnt) <= 1, 1);
    chk("R10", "cpu halt",       int'(cpu_halt), (who >= 0) ? 1 : 0);
    chk("R9",  "refresh row",    int'(rfsh_row), m_row);
    chk("R6",  "reuse flag",     int'(chr_reuse), int'(er));
    // advance as the coming clock edge will
    m_instr = ei - ((who == 2) ? 1 : 0);
    m_opnd  = eo - ((who == 3) ? 1 : 0);
    m_chr   = ec - ((who == 4) ? 1 : 0);
    m_reuse = er;
    m_bl    = m_bl + (refresh_req ? 1 : 0) - ((who == 5) ? 1 : 0);
    if (m_bl > 8) m_bl = 8;
    if (who == 5) m_row = (m_row + 1) % 128;
  endtask

  task automatic run_line(input int len, input string tag, input int rf_lo, input int rf_hi);
    for (int c = 0; c < len; c++) begin
      hcnt        = 8'(c);
      refresh_req = (c >= rf_lo && c <= rf_hi);
      #1;
      eval_and_step(tag);
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input bit m, input bit p, input bit d, input bit i,
                         input bit o, input bit b, input int w);
    msl_en = m; plr_en = p; dl_en = d; instr_due = i; opnd_pend = o;
    badline = b; pf_width = 2'(w);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hcnt = '0; refresh_req = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    m_instr = 0; m_opnd = 0; m_chr = 0; m_bl = 0; m_row = 0; m_reuse = 0;
    repeat (3) @(negedge clk);
    chk("R11", "row in reset",   int'(rfsh_row), 0);
    chk("R11", "grant in reset", int'(slot_gnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: after release, an empty line shows no pending work
    run_line(LINE, "R11", -1, -1);
    // R2: only player/missile slots
    set_cfg(1, 1, 0, 0, 0, 0, 2); run_line(LINE, "R2", -1, -1);
    // R7: everything at once, refresh bunched early
    set_cfg(1, 1, 1, 1, 1, 1, 2); run_line(LINE, "R7", 0, 8);
    // R3: missile off, instruction borrows cycle 0
    set_cfg(0, 0, 1, 1, 1, 1, 1); run_line(LINE, "R3", 10, 14);
    // R3: missile on, instruction at cycle 1
    set_cfg(1, 0, 1, 1, 0, 0, 2); run_line(LINE, "R3", -1, -1);
    // R4: operand collides with player 3
    set_cfg(1, 1, 1, 0, 1, 0, 2); run_line(LINE, "R4", -1, -1);
    // R4: operand takes player 3 cycle when players off
    set_cfg(1, 0, 1, 0, 1, 0, 2); run_line(LINE, "R4", -1, -1);
    // R5: widest playfield
    set_cfg(1, 1, 1, 1, 0, 1, 3); run_line(LINE, "R5", -1, -1);
    // R6: playfield off on badline with display list on
    set_cfg(1, 1, 1, 1, 0, 1, 0); run_line(LINE, "R6", 3, 6);
    // R6: same with display list off -> no reuse
    set_cfg(1, 1, 0, 0, 0, 1, 0); run_line(LINE, "R6", -1, -1);
    // R8: refresh flood inside a wide fetch, backlog saturates
    set_cfg(1, 1, 1, 0, 0, 1, 3); run_line(LINE, "R8", 20, 45);
    // R12: truncated line, leftover fetches dropped
    set_cfg(0, 0, 1, 1, 1, 1, 2); run_line(30, "R12", -1, -1);
    set_cfg(0, 0, 1, 0, 0, 0, 2); run_line(LINE, "R12", -1, -1);
    // R9: many refresh-heavy lines wrap the row counter
    for (int k = 0; k < 16; k++) begin
      set_cfg(1, 1, 1, k[0], 0, k[1], k % 4);
      run_line(LINE, "R9", 6, 15);
    end
    chk("R9", "row wrapped", (m_row < 128) ? 1 : 0, 1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule